// File: doc/BRIEF.md
# Center-Aligned PWM Channel with Dead Time

This block is one PWM output channel that produces a pulse centered on the peak of a shared up/down time base. A separate modulus counter drives the time base. It supplies a count value and a direction bit that is high while the count rises. The channel compares its active duty value against that count. A match while the count rises is the leading edge, where the output enters its asserted state. A match while the count falls is the trailing edge, where the output returns to idle.

Dead time is inserted on one edge, selected by the mode word. The duty match on that edge starts a private counter from zero. The output transition waits until that counter reaches the active dead-time value. The duty and dead-time values are written into staging inputs at any time. They are copied into the active registers only when the time base shows its minimum value of 1, which is the start of a period. A mid-period change therefore never distorts the pulse in progress. A one-cycle flag marks trailing edges, and also leading edges when the mode asks for both.

Top module: `cpwm_deadtime`

## Requirements
- R1: While reset is held and in the first cycle after it, `pwm_out` equals `pol` (idle level) and `flag` is 0.
- R2: The mode word is valid only when `mode[6:2]` is 5'b10111. In any cycle after a cycle with an invalid mode, `pwm_out` equals `pol`, `flag` is 0 and no delayed edge remains pending.
- R3: `duty_stage` and `dead_stage` are copied into the active registers at the clock edge ending a cycle in which `tb_cnt` equals 1. Stage changes at any other time have no effect on the output until that copy.
- R4: In a cycle where `tb_cnt` equals the active duty value, an undelayed edge takes effect one cycle later. The edge asserts the output if `tb_up` is 1 and returns it to idle if `tb_up` is 0.
- R5: `mode[0]` selects the edge that is delayed: 1 selects the leading edge and 0 selects the trailing edge. With an active dead-time value D, the delayed edge appears D+1 cycles later than it would undelayed.
- R6: `flag` is a one-cycle pulse in the same cycle that an output edge appears. It always marks trailing edges. It also marks leading edges when `mode[1]` is 1.
- R7: `pwm_out` is the internal asserted state XOR `pol`. With `pol` = 0 the asserted level is high, and with `pol` = 1 it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 7 | Mode word: [6:2] family code, [1] flag on both edges, [0] leading-edge dead time |
| tb_cnt | input | W | Shared time-base count |
| tb_up | input | 1 | Time-base direction, 1 while counting up |
| pol | input | 1 | Output polarity, which is the idle level |
| duty_stage | input | W | Staging duty value |
| dead_stage | input | W | Staging dead-time value |
| pwm_out | output | 1 | PWM output |
| flag | output | 1 | One-cycle edge flag |

## Verification
The bench drives a time base that runs 1 to 10 and back. It counts the active registers as valid from the cycle after the `tb_cnt` = 1 cycle, so an undelayed edge is due one cycle after its match cycle and a delayed edge is due D+2 cycles after it. The flag is due in the same cycle as the edge it marks. Inputs change just after a rising clock edge. Outputs are sampled at the following falling edge, so every compare sees the state registered at the start of that cycle. The bench sweeps every mode, polarity, dead time from 0 to 2 and each duty from 3 to 8. For each combination it checks a complete steady-state period with the expected waveform worked out arithmetically from edge positions, and it scrambles the stage inputs mid-period to confirm that nothing moves.

// File: rtl/cpwm_deadtime.sv
module cpwm_deadtime #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [6:0]   mode,
  input  logic [W-1:0] tb_cnt,
  input  logic         tb_up,
  input  logic         pol,
  input  logic [W-1:0] duty_stage,
  input  logic [W-1:0] dead_stage,
  output logic         pwm_out,
  output logic         flag
);
  localparam logic [4:0]   FAMILY = 5'b10111;
  localparam logic [W-1:0] TB_MIN = W'(1);

  logic [W-1:0] duty_q, dead_q, dcnt_q;
  logic         on_q, pend_q, tgt_q, flag_q;

  wire mode_ok = (mode[6:2] == FAMILY);
  wire lead_dt = mode[0];
  wire both_fl = mode[1];
  wire hit     = mode_ok && (tb_cnt == duty_q);
  wire hit_dt  = hit && (tb_up ? lead_dt : !lead_dt);
  wire hit_now = hit && !hit_dt;
  wire fire    = pend_q && (dcnt_q == dead_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      duty_q <= '0;
      dead_q <= '0;
    end else if (tb_cnt == TB_MIN) begin
      duty_q <= duty_stage;
      dead_q <= dead_stage;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= 1'b0;
      dcnt_q <= '0;
    end else if (!mode_ok) begin
      pend_q <= 1'b0;
      dcnt_q <= '0;
    end else if (hit_dt) begin
      pend_q <= 1'b1;
      tgt_q  <= tb_up;
      dcnt_q <= '0;
    end else if (fire) begin
      pend_q <= 1'b0;
    end else if (pend_q) begin
      dcnt_q <= dcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (!mode_ok) begin
      on_q   <= 1'b0;
      flag_q <= 1'b0;
    end else if (hit_now) begin
      on_q   <= tb_up;
      flag_q <= !tb_up || both_fl;
    end else if (fire) begin
      on_q   <= tgt_q;
      flag_q <= !tgt_q || both_fl;
    end else begin
      flag_q <= 1'b0;
    end
  end

  assign pwm_out = on_q ^ pol;
  assign flag    = flag_q;
endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [6:1]   mode_hi,
  input logic [W-1:0] tb_cnt,
  input logic         pol,
  input logic         pwm_out,
  input logic         flag,
  input logic [W-1:0] duty_q,
  input logic [W-1:0] dead_q,
  input logic         on_q,
  input logic         pend_q,
  input logic [W-1:0] dcnt_q
);
  wire ok = (mode_hi[6:2] == 5'b10111);

  p_idle_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ok |=> (pwm_out == pol) && !flag && !pend_q);

  p_reload_only_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_cnt != W'(1)) |=> $stable(duty_q) && $stable(dead_q));

  p_hold_in_dead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ok && pend_q && (dcnt_q != dead_q) && (tb_cnt != duty_q) |=> $stable(on_q));

  p_trail_flag_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !$past(mode_hi[1]) |-> (pwm_out == pol));
endmodule

bind cpwm_deadtime cpwm_deadtime_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_hi(mode[6:1]), .tb_cnt(tb_cnt), .pol(pol),
  .pwm_out(pwm_out), .flag(flag), .duty_q(duty_q), .dead_q(dead_q),
  .on_q(on_q), .pend_q(pend_q), .dcnt_q(dcnt_q)
);

// File: tb/cpwm_deadtime_bench.sv
`timescale 1ns/1ps
module cpwm_deadtime_bench;
  localparam int W  = 8;
  localparam int PK = 10;
  localparam int N  = 2*PK - 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] mode = 7'd0;
  logic [W-1:0] tb_cnt = '0, duty_stage = '0, dead_stage = '0;
  logic tb_up = 1'b0, pol = 1'b0;
  logic pwm_out, flag;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cpwm_deadtime #(.W(W)) u_cpwm_deadtime (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tb_cnt(tb_cnt), .tb_up(tb_up),
    .pol(pol), .duty_stage(duty_stage), .dead_stage(dead_stage),
    .pwm_out(pwm_out), .flag(flag));

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic drive_pos(input int p);
    @(posedge clk); #1;
    if (p < PK) begin tb_cnt = W'(p + 1); tb_up = 1'b1; end
    else begin tb_cnt = W'(2*PK - 1 - p); tb_up = 1'b0; end
    @(negedge clk);
  endtask

  task automatic run_cfg(input logic [6:0] md, input int d, input int dt, input logic pl);
    int il, it, L, T;
    logic lead, both, eon, efl;
    lead = md[0]; both = md[1];
    il = d - 1; it = 2*PK - 1 - d;
    L = il + 1 + (lead ? dt + 1 : 0);
    T = it + 1 + (!lead ? dt + 1 : 0);
    for (int p = 0; p < N; p++) begin
      if (p == 0) begin
        mode = md; pol = pl; duty_stage = W'(d); dead_stage = W'(dt);
      end
      drive_pos(p);
    end
    for (int p = 0; p < N; p++) begin
      drive_pos(p);
      eon = ((p >= L) && (p < T)) || (p + N < T);
      efl = (p == (T % N)) || (both && (p == L));
      check(pwm_out, eon ^ pl, "R4 R5 R7 output");
      check(flag, efl, "R6 flag");
      if (p == 3) begin duty_stage = W'(4); dead_stage = W'(1); end
      if (p == N - 1) begin duty_stage = W'(d); dead_stage = W'(dt); end
    end
  endtask

  initial begin
    #3000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pwm_out, 1'b0, "R1 reset pwm_out");
    check(flag, 1'b0, "R1 reset flag");
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(pwm_out, 1'b0, "R1 after reset pwm_out");
    check(flag, 1'b0, "R1 after reset flag");

    for (int m = 0; m < 4; m++)
      for (int pl = 0; pl < 2; pl++)
        for (int dt = 0; dt < 3; dt++)
          for (int d = 3; d <= 8; d++)
            run_cfg({5'b10111, 2'(m)}, d, dt, 1'(pl));

    // R2: invalid family code forces idle level and no flag
    mode = 7'b1011000; pol = 1'b1;
    for (int p = 0; p < N; p++) begin
      drive_pos(p);
      if (p > 0) begin
        check(pwm_out, 1'b1, "R2 invalid mode pwm_out");
        check(flag, 1'b0, "R2 invalid mode flag");
      end
    end

    // R3: staging captured at tb_cnt==1, observed in the sweep above; recheck after invalid mode
    run_cfg(7'b1011111, 5, 1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule